// File: doc/BRIEF.md
# Transmit Frame FIFO with Threshold-Gated Release

This block is a byte-wide transmit frame buffer placed between a host that writes frames and a MAC-side engine that reads them. Each stored byte carries a flag that marks the last byte of its frame. The buffer decides when the MAC side may begin reading a frame. In store-and-forward mode a frame is offered only once it is held complete, end byte included. In cut-through mode it is offered once the fill level reaches a start level, or once the end byte has arrived if the frame is shorter than that level. The start level comes from a byte-count request rounded up to one of five fixed steps.

A control sequencer with three states runs the block. `ST_WAIT` holds the read side closed and moves to `ST_SEND` when the release rule is met, or to `ST_FLUSH` on a flush request. `ST_SEND` offers bytes. It returns to `ST_WAIT` after the end byte is read. It moves to `ST_FLUSH` on a flush request, or on an underflow, which is the MAC side asking for data while the buffer is empty before the end of the frame. `ST_FLUSH` empties the buffer over a fixed number of cycles and then returns to `ST_WAIT`. During `ST_FLUSH` the busy flag reads high, so it clears itself when the flush is done. Each frame ends with a status pulse that carries an underflow flag. After an underflow, the rest of the broken frame from the host is taken in and thrown away. When operate-on-second-frame is off, the host may not begin the next frame until the status of the held frame has been returned.

Top module: `tx_frame_gate`

## Requirements
- R1: After reset, push_ready is 1 and pop_valid, flush_busy and stat_valid are 0.
- R2: Bytes leave in the order they were accepted, with their last flag. pop_sof is 1 on the first byte of each frame and 0 on every other byte.
- R3: With cfg_sf = 1, pop_valid stays 0 while the frame's end byte has not been accepted, whatever the threshold request. It becomes 1 in the second cycle after the end byte is accepted.
- R4: The start level is the smallest of 32, 64, 128, 192 and 256 bytes that is at least cfg_thr_req. Any request above 192 gives 256.
- R5: With cfg_sf = 0 and no complete frame held, pop_valid stays 0 while fewer bytes than the start level are held. It becomes 1 in the second cycle after the byte that reaches the level is accepted.
- R6: With cfg_sf = 0, a frame shorter than the start level is offered in the second cycle after its end byte is accepted.
- R7: In the cycle after the end byte of a frame is read, pop_valid is 0, even when a further frame is already held.
- R8: When DEPTH bytes are held, push_ready is 0.
- R9: With cfg_osf = 0, push_ready is 0 from the cycle after an end byte is accepted until that frame's status has been returned. With cfg_osf = 1, push_ready stays 1.
- R10: The cycle after a frame's end byte is read, stat_valid is 1 and stat_underflow is 0.
- R11: In ST_SEND, if pop_ready is 1 while the buffer is empty, the next cycle shows stat_valid = 1, stat_underflow = 1 and flush_busy = 1. The host's remaining bytes of that frame, up to and including its end byte, are accepted and dropped.
- R12: A flush_req pulse raises flush_busy from the next cycle for exactly FLUSH_CYCLES cycles. While it is high, push_ready and pop_valid are 0. Afterwards the buffer is empty and no status is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sf | input | 1 | 1 = store-and-forward, 0 = cut-through |
| cfg_osf | input | 1 | 1 = host may load the next frame before status returns |
| cfg_thr_req | input | REQ_W | Requested cut-through start level in bytes |
| flush_req | input | 1 | One-cycle request to empty the buffer |
| push_valid | input | 1 | Host byte present |
| push_data | input | DW | Host byte |
| push_last | input | 1 | Host byte is the end of its frame |
| push_ready | output | 1 | Host byte accepted this cycle when valid |
| pop_valid | output | 1 | Byte offered to the MAC side |
| pop_ready | input | 1 | MAC side takes or needs a byte |
| pop_data | output | DW | Offered byte |
| pop_last | output | 1 | Offered byte ends its frame |
| pop_sof | output | 1 | Offered byte starts its frame |
| flush_busy | output | 1 | Flush in progress; clears itself when done |
| stat_valid | output | 1 | One-cycle frame status pulse |
| stat_underflow | output | 1 | Status: the frame ran dry before its end |

## Verification
The properties assume that cfg_sf, cfg_osf and cfg_thr_req change only while the buffer is empty and the sequencer is waiting. They also assume that a host byte, once presented, is held with its flag until it is accepted. The stimulus changes the configuration only after every expected byte and status has been drained. The host driver keeps push_valid and its data steady until it sees push_ready. Underflow is provoked only in cut-through mode, by stopping the host in mid-frame while the MAC side keeps pop_ready high. A flush is requested only while no frame is being read.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SEND  = 2'd1,
        ST_FLUSH = 2'd2
    } gate_state_t;

    localparam int unsigned STEP_N = 5;

    function automatic int unsigned step_bytes(input int unsigned idx);
        int unsigned v;
        case (idx)
            0:       v = 32;
            1:       v = 64;
            2:       v = 128;
            3:       v = 192;
            default: v = 256;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/txg_level_map.sv
module txg_level_map
    import txg_pkg::*;
#(
    parameter int unsigned REQ_W = 12,
    parameter int unsigned CW    = 12
) (
    input  logic [REQ_W-1:0] req,
    output logic [CW-1:0]    level
);

    always_comb begin
        level = CW'(step_bytes(STEP_N - 1));
        for (int i = int'(STEP_N) - 2; i >= 0; i--) begin
            if (32'(req) <= step_bytes(i)) begin
                level = CW'(step_bytes(i));
            end
        end
    end

endmodule

// File: rtl/txg_store.sv
module txg_store #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic [CW-1:0] fill,
    output logic          empty,
    output logic          full
);

    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= {wr_last, wr_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign {rd_last, rd_data} = mem[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));

endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
    import txg_pkg::*;
#(
    parameter int unsigned CW           = 12,
    parameter int unsigned FLUSH_CYCLES = 4,
    localparam int unsigned FW          = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sf,
    input  logic          cfg_osf,
    input  logic [CW-1:0] thr_level,
    input  logic          flush_req,
    input  logic          push_valid,
    input  logic          push_last,
    input  logic          pop_ready,
    input  logic [CW-1:0] fill,
    input  logic          empty,
    input  logic          full,
    input  logic          head_last,
    output logic          push_ready,
    output logic          wr_en,
    output logic          rd_en,
    output logic          clr,
    output logic          pop_valid,
    output logic          pop_sof,
    output logic          flush_busy,
    output logic          stat_valid,
    output logic          stat_underflow,
    output logic [CW-1:0] frames_held,
    output logic          discard
);

    gate_state_t   state_q;
    gate_state_t   state_d;
    logic          first_q;
    logic [FW-1:0] flush_cnt_q;
    logic          push_fire;
    logic          uflow;
    logic          rel_ok;
    logic          flush_done;
    logic          frame_in;
    logic          frame_out;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (flush_req)   state_d = ST_FLUSH;
                else if (rel_ok) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (flush_req || uflow)  state_d = ST_FLUSH;
                else if (frame_out)      state_d = ST_WAIT;
            end
            ST_FLUSH: begin
                if (flush_done) state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        flush_busy = (state_q == ST_FLUSH);
        clr        = flush_busy;
        push_ready = !flush_busy &&
                     (discard || (!full && (cfg_osf || frames_held == '0)));
        push_fire  = push_valid && push_ready;
        wr_en      = push_fire && !discard;
        pop_valid  = (state_q == ST_SEND) && !empty;
        rd_en      = pop_valid && pop_ready;
        pop_sof    = pop_valid && first_q;
        uflow      = (state_q == ST_SEND) && pop_ready && empty && !flush_req;
        rel_ok     = (frames_held != '0) || (!cfg_sf && fill >= thr_level);
        flush_done = (flush_cnt_q == FW'(FLUSH_CYCLES - 1));
        frame_in   = wr_en && push_last;
        frame_out  = rd_en && head_last;
    end

    // frame bookkeeping, status and flush timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q        <= 1'b0;
            flush_cnt_q    <= '0;
            frames_held    <= '0;
            discard        <= 1'b0;
            stat_valid     <= 1'b0;
            stat_underflow <= 1'b0;
        end else begin
            if (state_q == ST_WAIT && state_d == ST_SEND) first_q <= 1'b1;
            else if (rd_en)                               first_q <= 1'b0;

            if (state_q == ST_FLUSH) flush_cnt_q <= flush_cnt_q + 1'b1;
            else                     flush_cnt_q <= '0;

            if (state_q == ST_FLUSH) frames_held <= '0;
            else frames_held <= frames_held + CW'(frame_in) - CW'(frame_out);

            if (uflow)                         discard <= !(push_fire && push_last);
            else if (push_fire && push_last)   discard <= 1'b0;

            stat_valid     <= frame_out || uflow;
            stat_underflow <= uflow;
        end
    end

endmodule

// File: rtl/tx_frame_gate.sv
module tx_frame_gate
    import txg_pkg::*;
#(
    parameter int unsigned DEPTH        = 2048,
    parameter int unsigned DW           = 8,
    parameter int unsigned REQ_W        = 12,
    parameter int unsigned FLUSH_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sf,
    input  logic             cfg_osf,
    input  logic [REQ_W-1:0] cfg_thr_req,
    input  logic             flush_req,
    input  logic             push_valid,
    input  logic [DW-1:0]    push_data,
    input  logic             push_last,
    output logic             push_ready,
    output logic             pop_valid,
    input  logic             pop_ready,
    output logic [DW-1:0]    pop_data,
    output logic             pop_last,
    output logic             pop_sof,
    output logic             flush_busy,
    output logic             stat_valid,
    output logic             stat_underflow
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] thr_level;
    logic [CW-1:0] fill_level;
    logic [CW-1:0] frames_held;
    logic          discard;
    logic          wr_en;
    logic          rd_en;
    logic          clr;
    logic          empty;
    logic          full;
    logic          head_last;

    txg_level_map #(.REQ_W(REQ_W), .CW(CW)) u_map (
        .req   (cfg_thr_req),
        .level (thr_level)
    );

    txg_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_data (push_data),
        .wr_last (push_last),
        .rd_en   (rd_en),
        .rd_data (pop_data),
        .rd_last (head_last),
        .fill    (fill_level),
        .empty   (empty),
        .full    (full)
    );

    txg_ctrl #(.CW(CW), .FLUSH_CYCLES(FLUSH_CYCLES)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_sf         (cfg_sf),
        .cfg_osf        (cfg_osf),
        .thr_level      (thr_level),
        .flush_req      (flush_req),
        .push_valid     (push_valid),
        .push_last      (push_last),
        .pop_ready      (pop_ready),
        .fill           (fill_level),
        .empty          (empty),
        .full           (full),
        .head_last      (head_last),
        .push_ready     (push_ready),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .clr            (clr),
        .pop_valid      (pop_valid),
        .pop_sof        (pop_sof),
        .flush_busy     (flush_busy),
        .stat_valid     (stat_valid),
        .stat_underflow (stat_underflow),
        .frames_held    (frames_held),
        .discard        (discard)
    );

    assign pop_last = pop_valid && head_last;

endmodule

// File: rtl/tx_frame_gate_chk.sv
module tx_frame_gate_chk #(
    parameter int unsigned DEPTH        = 2048,
    parameter int unsigned FLUSH_CYCLES = 4,
    parameter int unsigned CW           = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          push_ready,
    input logic          push_last,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic          pop_last,
    input logic          flush_busy,
    input logic          stat_valid,
    input logic          stat_underflow,
    input logic          cfg_sf,
    input logic          cfg_osf,
    input logic [CW-1:0] fill,
    input logic [CW-1:0] frames_held,
    input logic          discard
);

    localparam int unsigned BW = $clog2(FLUSH_CYCLES + 2);

    logic [BW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_run <= '0;
        else if (flush_busy) busy_run <= busy_run + 1'b1;
        else                 busy_run <= '0;
    end

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!push_ready && !pop_valid)); // R12

    AST_FLUSH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (busy_run < BW'(FLUSH_CYCLES))); // R12

    AST_UFLOW_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_underflow) |-> flush_busy); // R11

    AST_UFLOW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_underflow |-> stat_valid); // R11

    AST_GATE_RECLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_ready && pop_last) |=> !pop_valid); // R7

    AST_SF_WHOLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sf && $rose(pop_valid)) |-> (frames_held != '0)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R8

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH) && !discard) |-> !push_ready); // R8

    AST_ONE_FRAME_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_osf && push_valid && push_ready && push_last && !discard)
        |=> !push_ready); // R9

endmodule

bind tx_frame_gate tx_frame_gate_chk #(
    .DEPTH        (DEPTH),
    .FLUSH_CYCLES (FLUSH_CYCLES),
    .CW           (CW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_valid     (push_valid),
    .push_ready     (push_ready),
    .push_last      (push_last),
    .pop_valid      (pop_valid),
    .pop_ready      (pop_ready),
    .pop_last       (pop_last),
    .flush_busy     (flush_busy),
    .stat_valid     (stat_valid),
    .stat_underflow (stat_underflow),
    .cfg_sf         (cfg_sf),
    .cfg_osf        (cfg_osf),
    .fill           (fill_level),
    .frames_held    (frames_held),
    .discard        (discard)
);

// File: tb/tb_tx_frame_gate.sv
module tb_tx_frame_gate;

    localparam int unsigned DEPTH        = 256;
    localparam int unsigned DW           = 8;
    localparam int unsigned REQ_W        = 12;
    localparam int unsigned FLUSH_CYCLES = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_sf;
    logic             cfg_osf;
    logic [REQ_W-1:0] cfg_thr_req;
    logic             flush_req;
    logic             push_valid;
    logic [DW-1:0]    push_data;
    logic             push_last;
    logic             push_ready;
    logic             pop_valid;
    logic             pop_ready = 1'b0;
    logic [DW-1:0]    pop_data;
    logic             pop_last;
    logic             pop_sof;
    logic             flush_busy;
    logic             stat_valid;
    logic             stat_underflow;

    always #10 clk = ~clk;

    tx_frame_gate #(
        .DEPTH(DEPTH), .DW(DW), .REQ_W(REQ_W), .FLUSH_CYCLES(FLUSH_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sf(cfg_sf), .cfg_osf(cfg_osf),
        .cfg_thr_req(cfg_thr_req), .flush_req(flush_req),
        .push_valid(push_valid), .push_data(push_data), .push_last(push_last),
        .push_ready(push_ready), .pop_valid(pop_valid), .pop_ready(pop_ready),
        .pop_data(pop_data), .pop_last(pop_last), .pop_sof(pop_sof),
        .flush_busy(flush_busy), .stat_valid(stat_valid),
        .stat_underflow(stat_underflow)
    );

    int checks = 0;
    int errors = 0;
    bit mac_en = 0;
    bit drop = 0;
    bit in_frame = 0;
    bit stat_due = 0;
    bit gate_due = 0;
    bit finished = 0;
    logic [DW+1:0] exp_q[$];
    bit            stat_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one byte, held until accepted; expected items go to the scoreboard
    task automatic push_one(input logic [DW-1:0] d, input bit l);
        push_valid = 1'b1;
        push_data  = d;
        push_last  = l;
        while (!push_ready) @(negedge clk);
        if (!drop) begin
            exp_q.push_back({!in_frame, l, d});
            if (l) stat_q.push_back(1'b0);
        end
        in_frame = !l;
        @(negedge clk);
        push_valid = 1'b0;
        push_last  = 1'b0;
    endtask

    task automatic push_run(input int n, input bit end_last, input int seed);
        for (int i = 0; i < n; i++) push_one(DW'(seed + i), end_last && (i == n - 1));
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || stat_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            pop_ready = mac_en;
            if (stat_due) begin
                check(stat_valid == 1'b1, "R10 status one cycle after end byte", stat_valid, 1);
                stat_due = 0;
            end
            if (gate_due) begin
                check(pop_valid == 1'b0, "R7 gate closed after end byte", pop_valid, 0);
                gate_due = 0;
            end
            if (pop_valid && pop_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected byte", int'({pop_sof, pop_last, pop_data}), -1);
                end else begin
                    logic [DW+1:0] e;
                    e = exp_q.pop_front();
                    check({pop_sof, pop_last, pop_data} == e, "R2 byte sof/last/data",
                          int'({pop_sof, pop_last, pop_data}), int'(e));
                end
                if (pop_last) begin
                    stat_due = 1;
                    gate_due = 1;
                end
            end
            if (stat_valid) begin
                if (stat_q.size() == 0) begin
                    check(1'b0, "R12 unexpected status", stat_underflow, -1);
                end else begin
                    bit u;
                    u = stat_q.pop_front();
                    check(stat_underflow == u, u ? "R11 underflow status" : "R10 good status",
                          stat_underflow, u);
                end
            end
        end
    end

    task automatic ct_test(input int req, input int lvl, input int total);
        cfg_sf      = 1'b0;
        cfg_thr_req = REQ_W'(req);
        mac_en      = 1;
        push_run(lvl - 1, 0, req);
        repeat (3) @(negedge clk);
        check(pop_valid == 1'b0, "R5 held below start level", pop_valid, 0);
        push_one(DW'(req + lvl - 1), 0);
        @(negedge clk);
        check(pop_valid == 1'b1, $sformatf("R4 request %0d releases at %0d", req, lvl), pop_valid, 1);
        push_run(total - lvl, 1, req + lvl);
        wait_drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_sf = 1'b1; cfg_osf = 1'b1; cfg_thr_req = '0; flush_req = 1'b0;
        push_valid = 1'b0; push_data = '0; push_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(push_ready == 1'b1, "R1 push_ready after reset", push_ready, 1);
        check(pop_valid == 1'b0, "R1 pop_valid after reset", pop_valid, 0);
        check(flush_busy == 1'b0, "R1 flush_busy after reset", flush_busy, 0);
        check(stat_valid == 1'b0, "R1 stat_valid after reset", stat_valid, 0);

        // R3: store-and-forward ignores the threshold
        cfg_sf = 1'b1; cfg_thr_req = 12'd32; mac_en = 1;
        push_run(40, 0, 8'h10);
        repeat (3) @(negedge clk);
        check(pop_valid == 1'b0, "R3 no release before end byte", pop_valid, 0);
        push_one(8'hA5, 1);
        @(negedge clk);
        check(pop_valid == 1'b1, "R3 release after end byte", pop_valid, 1);
        wait_drain();

        // R4/R5: cut-through start levels, including step boundaries
        ct_test(20, 32, 40);
        ct_test(32, 32, 35);
        ct_test(33, 64, 66);
        ct_test(100, 128, 130);
        ct_test(192, 192, 195);
        ct_test(193, 256, 260);

        // R6: short frame under a 256-byte level
        cfg_sf = 1'b0; cfg_thr_req = 12'd200; mac_en = 1;
        push_run(9, 0, 8'h40);
        repeat (2) @(negedge clk);
        check(pop_valid == 1'b0, "R6 short frame held before end", pop_valid, 0);
        push_one(8'h49, 1);
        @(negedge clk);
        check(pop_valid == 1'b1, "R6 short frame released on end", pop_valid, 1);
        wait_drain();

        // R7/R9: two frames queued with operate-on-second-frame
        cfg_sf = 1'b1; cfg_osf = 1'b1; mac_en = 0;
        push_run(6, 1, 8'h60);
        check(push_ready == 1'b1, "R9 osf keeps push open", push_ready, 1);
        push_run(7, 1, 8'h70);
        mac_en = 1;
        wait_drain();

        // R9: without operate-on-second-frame the host waits for status
        cfg_osf = 1'b0; mac_en = 0;
        push_run(10, 1, 8'h80);
        check(push_ready == 1'b0, "R9 push blocked after end byte", push_ready, 0);
        repeat (5) @(negedge clk);
        check(push_ready == 1'b0, "R9 push still blocked", push_ready, 0);
        mac_en = 1;
        wait_drain();
        check(push_ready == 1'b1, "R9 push reopens after status", push_ready, 1);
        cfg_osf = 1'b1;

        // R11: underflow in cut-through, tail dropped
        cfg_sf = 1'b0; cfg_thr_req = 12'd32; mac_en = 1;
        push_run(32, 0, 8'h90);
        stat_q.push_back(1'b1);
        while (!flush_busy) @(negedge clk);
        check(exp_q.size() == 0, "R11 head bytes delivered", exp_q.size(), 0);
        while (flush_busy) @(negedge clk);
        drop = 1;
        push_run(8, 1, 8'hB0);
        drop = 0;
        repeat (10) @(negedge clk);
        check(pop_valid == 1'b0, "R11 tail bytes dropped", pop_valid, 0);
        check(stat_q.size() == 0, "R11 status returned", stat_q.size(), 0);
        push_run(5, 1, 8'hC0);
        wait_drain();

        // R8: full buffer stalls the host
        cfg_sf = 1'b1; mac_en = 0; drop = 1;
        push_run(DEPTH, 0, 8'h00);
        check(push_ready == 1'b0, "R8 push_ready low when full", push_ready, 0);
        check(pop_valid == 1'b0, "R8 no release without end byte", pop_valid, 0);

        // R12: flush empties the buffer in a fixed number of cycles
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        begin
            int n;
            n = 0;
            while (flush_busy && n < 100) begin
                check(!push_ready && !pop_valid, "R12 ports closed during flush",
                      {push_ready, pop_valid}, 0);
                n++;
                @(negedge clk);
            end
            check(n == FLUSH_CYCLES, "R12 flush length", n, FLUSH_CYCLES);
        end
        drop = 0; in_frame = 0; mac_en = 1;
        repeat (5) @(negedge clk);
        check(pop_valid == 1'b0, "R12 buffer empty after flush", pop_valid, 0);
        check(push_ready == 1'b1, "R12 push open after flush", push_ready, 1);
        push_run(3, 1, 8'hD0);
        wait_drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule